// File: doc/BRIEF.md
# Compare Output Waveform Unit

This block is the output stage behind a timer's compare channels. It has two channels. The primary channel is A and the secondary channel is B. Each channel holds one waveform bit. The block updates that bit from four counter events: the channel's compare-match pulse, the BOTTOM strobe, the count direction and the counter's mode class. The mode class is one of three: plain (non-PWM), single-slope fast PWM, or dual-slope PWM. A 2-bit action code per channel selects what a match or a BOTTOM event does. The meaning of that code changes with the mode class.

For each pin, the block also chooses between the waveform bit and the normal port value. It passes the pin's direction bit through as the driver enable. The counter is not part of this block. It arrives only as strobes and status bits.

All ports are plain control and status pins. There is no streamed data, so the block has no valid/ready handshake. The waveform bits change on the clock edge after the event that causes them.

Top module: `cmp_wave_out`

## Requirements
- R1: Action code 00 disconnects a channel. Its pin carries the port value, and its waveform bit holds in every mode class.
- R2: A connected channel drives its pin with the waveform bit. For every code, pin_oe of a channel equals its dir bit.
- R3: Mode class 00 (plain) and class 11 both use the plain decode. On a match, code 01 toggles the waveform bit, 10 clears it and 11 sets it. The result is visible one edge later.
- R4: In mode class 01 (fast PWM), code 10 clears on a match and sets on BOTTOM. Code 11 sets on a match and clears on BOTTOM.
- R5: In classes 01 and 10, code 01 makes channel A toggle on a match only when wide_toggle is 1. Otherwise channel A is disconnected (R1 behaviour). Channel B with code 01 is always disconnected in these classes.
- R6: In mode class 10 (dual-slope), code 10 clears on a match while cnt_down is 0 and sets on a match while cnt_down is 1. Code 11 does the opposite.
- R7: In fast PWM with code 1x and cmp_eq_top high, a match is ignored, and the BOTTOM action still applies.
- R8: In dual-slope with code 1x and cmp_eq_top high, the waveform bit takes its count-up match level every cycle: 0 for code 10 and 1 for code 11. Match and direction have no effect.
- R9: In fast PWM, when a match and BOTTOM occur in the same cycle, the match action is applied.
- R10: Reset (rst_n low) clears both waveform bits to 0.
- R11: A force_cmp pulse applies the plain match action of R3 in the plain classes. In classes 01 and 10 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_class | input | 2 | 00 plain, 01 fast PWM, 10 dual-slope, 11 plain |
| wide_toggle | input | 1 | Enables the code-01 toggle on channel A in PWM classes |
| cnt_down | input | 1 | Counter is counting down |
| at_bottom | input | 1 | Counter BOTTOM strobe |
| act_code | input | 4 | [1:0] channel A code, [3:2] channel B code |
| match | input | 2 | Compare-match pulse per channel (bit 0 = A) |
| cmp_eq_top | input | 2 | Channel's compare value equals TOP |
| force_cmp | input | 2 | Forced-compare strobe per channel |
| port_val | input | 2 | Normal port value per pin |
| dir | input | 2 | Direction bit per pin |
| wave | output | 2 | Waveform bits |
| pin_val | output | 2 | Value driven toward each pin |
| pin_oe | output | 2 | Pin driver enable |

## Verification
The same match and BOTTOM pulses are applied under each mode class and action code, so that the decode is exercised in every combination. A toggle, a clear and a set each leave a different bit pattern after a chosen starting state, so each one is identified by the result. Coincident match and BOTTOM pulses, and compare values at TOP, expose which event takes priority. Running the plain decode in class 11 with cnt_down high tells the plain decode apart from the dual-slope one. Changing the port value while a channel is disconnected shows whether the pin really follows the port.

// File: rtl/cow_pkg.sv
package cow_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN = 2'b00,
    CLS_FAST  = 2'b01,
    CLS_DUAL  = 2'b10,
    CLS_ALT   = 2'b11
  } wave_class_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } wave_act_e;

  localparam int CODE_W = 2;
endpackage

// File: rtl/cow_action.sv
module cow_action
  import cow_pkg::*;
#(
  parameter bit IS_PRIMARY = 1'b1
) (
  input  wave_class_e        cls,
  input  logic               wide_toggle,
  input  logic               cnt_down,
  input  logic               at_bottom,
  input  logic [CODE_W-1:0]  code,
  input  logic               match,
  input  logic               eq_top,
  input  logic               force_cmp,
  output wave_act_e          act,
  output logic               connect
);
  logic pwm;
  logic tgl_ok;

  assign pwm    = (cls == CLS_FAST) || (cls == CLS_DUAL);
  assign tgl_ok = IS_PRIMARY && wide_toggle;

  always_comb begin
    connect = (code != 2'b00);
    if (pwm && code == 2'b01 && !tgl_ok) connect = 1'b0;

    act = ACT_HOLD;
    if (!pwm) begin
      if (match || force_cmp) begin
        case (code)
          2'b01:   act = ACT_TGL;
          2'b10:   act = ACT_CLR;
          2'b11:   act = ACT_SET;
          default: act = ACT_HOLD;
        endcase
      end
    end else if (code == 2'b01) begin
      if (tgl_ok && match) act = ACT_TGL;
    end else if (code[1]) begin
      if (cls == CLS_FAST) begin
        if (match && !eq_top)  act = code[0] ? ACT_SET : ACT_CLR;
        else if (at_bottom)    act = code[0] ? ACT_CLR : ACT_SET;
      end else begin
        if (eq_top)            act = code[0] ? ACT_SET : ACT_CLR;
        else if (match)        act = (code[0] ^ cnt_down) ? ACT_SET : ACT_CLR;
      end
    end
  end
endmodule

// File: rtl/cow_channel.sv
module cow_channel
  import cow_pkg::*;
#(
  parameter bit IS_PRIMARY = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wave_class_e        cls,
  input  logic               wide_toggle,
  input  logic               cnt_down,
  input  logic               at_bottom,
  input  logic [CODE_W-1:0]  code,
  input  logic               match,
  input  logic               eq_top,
  input  logic               force_cmp,
  input  logic               port_val,
  input  logic               dir,
  output logic               wave,
  output logic               pin_val,
  output logic               pin_oe
);
  wave_act_e act;
  logic      connect;
  logic      wave_q;

  cow_action #(.IS_PRIMARY(IS_PRIMARY)) u_act (
    .cls(cls), .wide_toggle(wide_toggle), .cnt_down(cnt_down),
    .at_bottom(at_bottom), .code(code), .match(match), .eq_top(eq_top),
    .force_cmp(force_cmp), .act(act), .connect(connect)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_q <= 1'b0;
    end else begin
      case (act)
        ACT_CLR: wave_q <= 1'b0;
        ACT_SET: wave_q <= 1'b1;
        ACT_TGL: wave_q <= ~wave_q;
        default: wave_q <= wave_q;
      endcase
    end
  end

  assign wave    = wave_q;
  assign pin_val = connect ? wave_q : port_val;
  assign pin_oe  = dir;

  // R1
  code_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b00) |=> $stable(wave_q));
  // R3
  plain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls == CLS_PLAIN) && code == 2'b11 && match) |=> wave_q);
  // R4
  fast_bottom_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls == CLS_FAST) && code == 2'b10 && at_bottom && !match) |=> wave_q);
  // R6
  dual_up_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls == CLS_DUAL) && code == 2'b10 && match && !cnt_down && !eq_top) |=> !wave_q);
  // R7
  fast_top_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls == CLS_FAST) && code[1] && eq_top && !at_bottom) |=> $stable(wave_q));
  // R8
  dual_top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls == CLS_DUAL) && code == 2'b11 && eq_top) |=> wave_q);
endmodule

// File: rtl/cmp_wave_out.sv
module cmp_wave_out
  import cow_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_class,
  input  logic                     wide_toggle,
  input  logic                     cnt_down,
  input  logic                     at_bottom,
  input  logic [NUM_CH*CODE_W-1:0] act_code,
  input  logic [NUM_CH-1:0]        match,
  input  logic [NUM_CH-1:0]        cmp_eq_top,
  input  logic [NUM_CH-1:0]        force_cmp,
  input  logic [NUM_CH-1:0]        port_val,
  input  logic [NUM_CH-1:0]        dir,
  output logic [NUM_CH-1:0]        wave,
  output logic [NUM_CH-1:0]        pin_val,
  output logic [NUM_CH-1:0]        pin_oe
);
  wave_class_e cls;
  assign cls = wave_class_e'(mode_class);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cow_channel #(.IS_PRIMARY(c == 0)) u_ch (
      .clk(clk), .rst_n(rst_n), .cls(cls), .wide_toggle(wide_toggle),
      .cnt_down(cnt_down), .at_bottom(at_bottom),
      .code(act_code[c*CODE_W +: CODE_W]), .match(match[c]),
      .eq_top(cmp_eq_top[c]), .force_cmp(force_cmp[c]),
      .port_val(port_val[c]), .dir(dir[c]),
      .wave(wave[c]), .pin_val(pin_val[c]), .pin_oe(pin_oe[c])
    );
  end
endmodule

// File: tb/cmp_wave_out_test.sv
module cmp_wave_out_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_class = 2'b00;
  logic       wide_toggle = 1'b0, cnt_down = 1'b0, at_bottom = 1'b0;
  logic [3:0] act_code = 4'h0;
  logic [1:0] match = 2'b00, cmp_eq_top = 2'b00, force_cmp = 2'b00;
  logic [1:0] port_val = 2'b10, dir = 2'b01;
  logic [1:0] wave, pin_val, pin_oe;

  typedef struct {
    logic [1:0] w;
    logic [1:0] p;
    logic [1:0] o;
    string      tag;
  } exp_t;
  exp_t sb[$];

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  cmp_wave_out uut (
    .clk(clk), .rst_n(rst_n), .mode_class(mode_class), .wide_toggle(wide_toggle),
    .cnt_down(cnt_down), .at_bottom(at_bottom), .act_code(act_code),
    .match(match), .cmp_eq_top(cmp_eq_top), .force_cmp(force_cmp),
    .port_val(port_val), .dir(dir), .wave(wave), .pin_val(pin_val), .pin_oe(pin_oe)
  );

  always #5 clk = ~clk;

  task automatic cmp(input logic [1:0] w, p, o, input string tag);
    compared++;
    if (wave !== w || pin_val !== p || pin_oe !== o) begin
      mismatched++;
      $display("FAIL %s: wave=%b pin=%b oe=%b expected wave=%b pin=%b oe=%b",
               tag, wave, pin_val, pin_oe, w, p, o);
    end
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.w, e.p, e.o, e.tag);
      end
    end
  end

  task automatic nb();
    @(negedge clk);
    match = 2'b00; force_cmp = 2'b00; at_bottom = 1'b0;
  endtask

  task automatic push(input logic [1:0] w, p, o, input string tag);
    exp_t e;
    e.w = w; e.p = p; e.o = o; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    nb(); rst_n = 1'b1;
    #1 cmp(2'b00, 2'b10, 2'b01, "R10 reset");
    // R10/R1: idle, codes 00
    nb(); push(2'b00, 2'b10, 2'b01, "R1");
    // R3 plain: A toggle, B set
    nb(); act_code = 4'b1101; match = 2'b11; push(2'b11, 2'b11, 2'b01, "R3 tgl/set");
    nb(); match = 2'b11; push(2'b10, 2'b10, 2'b01, "R3 tgl again");
    nb(); act_code = 4'b1011; match = 2'b01; push(2'b11, 2'b11, 2'b01, "R3 set A");
    nb(); act_code = 4'b1010; match = 2'b11; push(2'b00, 2'b00, 2'b01, "R3 clr");
    // R1/R2: A disconnected follows port, B overridden
    nb(); port_val = 2'b01; act_code = 4'b1100; match = 2'b11; push(2'b10, 2'b11, 2'b01, "R1 R2");
    nb(); dir = 2'b10; push(2'b10, 2'b11, 2'b10, "R2 oe");
    // R11 force
    nb(); act_code = 4'b1001; force_cmp = 2'b11; push(2'b01, 2'b01, 2'b10, "R11 force");
    nb(); mode_class = 2'b01; act_code = 4'b1111; force_cmp = 2'b11; push(2'b01, 2'b01, 2'b10, "R11 ignored");
    // R4 fast PWM
    nb(); act_code = 4'b1110; match = 2'b11; push(2'b10, 2'b10, 2'b10, "R4 match");
    nb(); at_bottom = 1'b1; push(2'b01, 2'b01, 2'b10, "R4 bottom");
    // R9 coincident
    nb(); match = 2'b11; at_bottom = 1'b1; push(2'b10, 2'b10, 2'b10, "R9");
    // R7 compare at TOP
    nb(); cmp_eq_top = 2'b01; match = 2'b11; at_bottom = 1'b1; push(2'b11, 2'b11, 2'b10, "R7 bottom");
    nb(); match = 2'b01; push(2'b11, 2'b11, 2'b10, "R7 ignore");
    // R5 toggle code in PWM class
    nb(); cmp_eq_top = 2'b00; act_code = 4'b0101; port_val = 2'b00; match = 2'b11;
    push(2'b11, 2'b00, 2'b10, "R5 off");
    nb(); wide_toggle = 1'b1; port_val = 2'b11; match = 2'b11; push(2'b10, 2'b10, 2'b10, "R5 on");
    // R6 dual slope
    nb(); mode_class = 2'b10; act_code = 4'b1110; cnt_down = 1'b1; match = 2'b11;
    push(2'b01, 2'b01, 2'b10, "R6 down");
    nb(); cnt_down = 1'b0; match = 2'b11; push(2'b10, 2'b10, 2'b10, "R6 up");
    // R8 compare at TOP in dual slope
    nb(); act_code = 4'b1111; cmp_eq_top = 2'b01; cnt_down = 1'b1; push(2'b11, 2'b11, 2'b10, "R8 level");
    nb(); match = 2'b01; push(2'b11, 2'b11, 2'b10, "R8 hold");
    // R3 class 11 uses plain decode
    nb(); mode_class = 2'b11; cmp_eq_top = 2'b00; act_code = 4'b1110; match = 2'b01;
    push(2'b10, 2'b10, 2'b10, "R3 class11");
    nb(); nb(); nb();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule